// File: doc/BRIEF.md
# Sensor Raster Readout Sequencer

This block sequences the readout of a two-dimensional charge-coupled image sensor. A start request opens an exposure of a programmed number of clock cycles. The block then reads the image one row at a time. It asks the phase clock generator for one row transfer into the horizontal output register, then for one pixel transfer per column, and it strobes an external converter for each pixel that lies inside the selected window. Every transfer request stays high until the clock generator answers with a one-cycle done. Pixels outside a valid rectangular window are still shifted out, but they are never converted.

Two operating modes are available. In the direct mode the sensor stays dark while it is read: the shutter is closed for the whole readout, and a new start is refused until the frame finishes. In the buffered mode the exposed charge is first moved, row by row, into a masked store of equal height. The store is then read at the pixel rate while a following exposure may already run. If that exposure ends before the store is empty, it waits and keeps integrating.

Configuration is captured when a start is accepted. The readout engine keeps its own copy, so the next buffered exposure may use different settings.

Top module: `ccd_readout_seq`

## Requirements
- R1: While reset is applied and right after it, every request, strobe, `pixel_valid`, `frame_done`, `shutter_open` and `busy` are low.
- R2: An accepted start raises `shutter_open` on the next cycle. It stays high for exactly `int_len` cycles, or for 1 cycle when `int_len` is 0, unless a buffered exposure has to wait for the store.
- R3: Each request (`xfer_req`, `par_shift_req`, `ser_shift_req`) stays high until its done input is seen high. One handshake equals one transfer. Each row transfer is followed by exactly `num_cols` pixel transfers before the next row transfer, so a frame has `num_rows` row and `num_rows*num_cols` pixel transfers.
- R4: Converted pixels come out in raster order: column index rising within a row, then row index rising. `row_idx`/`col_idx` name the pixel whenever `pixel_valid` is high.
- R5: With `roi_en` high and a valid window, only pixels with row in [`roi_row_lo`,`roi_row_hi`] and column in [`roi_col_lo`,`roi_col_hi`] (inclusive) are converted. Pixels outside it are transferred but skip conversion.
- R6: A window with lo > hi on either axis, or hi ≥ the array size on either axis, is treated as the whole array.
- R7: A conversion lasts `ADC_BITS` cycles, one per result bit (12 bits gives 4096 levels). `adc_convert` is high in its first cycle only and `pixel_valid` in its last cycle only. The conversion starts on the cycle after the pixel transfer handshake.
- R8: In direct mode (`mode_ft`=0), readout starts on the cycle after the last exposure cycle, and `shutter_open` is low for the whole readout.
- R9: In buffered mode (`mode_ft`=1), exposure is followed by `num_rows` store-transfer handshakes on `xfer_req`, issued only while no readout is active; readout starts on the cycle after the last one. A new buffered exposure may overlap that readout.
- R10: `start_frame` is ignored while an exposure or store transfer is in progress, and also when a direct-mode start meets an active readout or a buffered start meets an active direct-mode readout.
- R11: `frame_done` is a one-cycle pulse on the cycle after the last pixel's final step (its transfer, or its conversion when it is in the window).
- R12: `busy` is high exactly while an exposure, a store transfer or a readout is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_frame | input | 1 | Request to begin a frame |
| mode_ft | input | 1 | 1 = buffered (store) mode, 0 = direct mode |
| int_len | input | INT_W | Exposure length in cycles (0 acts as 1) |
| num_rows | input | ROW_W | Array height, at least 1 |
| num_cols | input | COL_W | Array width, at least 1 |
| roi_en | input | 1 | Window enable |
| roi_row_lo | input | ROW_W | First window row |
| roi_row_hi | input | ROW_W | Last window row |
| roi_col_lo | input | COL_W | First window column |
| roi_col_hi | input | COL_W | Last window column |
| xfer_done | input | 1 | Store-transfer step finished |
| par_shift_done | input | 1 | Row transfer finished |
| ser_shift_done | input | 1 | Pixel transfer finished |
| xfer_req | output | 1 | Request a row step from image area into store |
| par_shift_req | output | 1 | Request a row transfer into the output register |
| ser_shift_req | output | 1 | Request a pixel transfer to the output node |
| adc_convert | output | 1 | Converter start strobe |
| pixel_valid | output | 1 | Conversion of the indexed pixel completes |
| row_idx | output | ROW_W | Current row |
| col_idx | output | COL_W | Current column |
| frame_done | output | 1 | Frame readout finished |
| shutter_open | output | 1 | Sensor is integrating |
| busy | output | 1 | Exposure, transfer or readout active |

## Verification
The assertions assume that a done input rises only while its own request is high, and only for a single cycle. They also assume that array sizes are at least one. The bench drives each done from a responder that waits a chosen latency after it sees the request, asserts done for one cycle, and then drops it. All frames use nonzero sizes. Window corners are varied across valid, reversed and out-of-range settings, and the bench cross-checks window contents against its own pixel list.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

   typedef enum logic [1:0] {
      EX_IDLE,
      EX_INTEG,
      EX_HOLD,
      EX_DUMP
   } ex_state_e;

   typedef enum logic [2:0] {
      RD_IDLE,
      RD_ROWSH,
      RD_PIXSH,
      RD_CONV,
      RD_END
   } rd_state_e;

endpackage

// File: rtl/ccd_roi_window.sv
module ccd_roi_window #(
   parameter int ROW_W = 10,
   parameter int COL_W = 10
) (
   input  logic [ROW_W-1:0] rows,
   input  logic [COL_W-1:0] cols,
   input  logic             roi_en,
   input  logic [ROW_W-1:0] row_lo,
   input  logic [ROW_W-1:0] row_hi,
   input  logic [COL_W-1:0] col_lo,
   input  logic [COL_W-1:0] col_hi,
   input  logic [ROW_W-1:0] cur_row,
   input  logic [COL_W-1:0] cur_col,
   output logic             in_win
);

   logic rows_ok, cols_ok, win_ok, row_hit, col_hit;

   // hi must lie strictly below the array size
   assign rows_ok = (row_lo <= row_hi) && (row_hi < rows);
   assign cols_ok = (col_lo <= col_hi) && (col_hi < cols);
   assign win_ok  = roi_en && rows_ok && cols_ok;

   assign row_hit = (cur_row >= row_lo) && (cur_row <= row_hi);
   assign col_hit = (cur_col >= col_lo) && (cur_col <= col_hi);

   // invalid or disabled window -> whole array is converted
   assign in_win  = !win_ok || (row_hit && col_hit);

endmodule

// File: rtl/ccd_expose_ctrl.sv
module ccd_expose_ctrl
   import ccd_seq_pkg::*;
#(
   parameter int ROW_W = 10,
   parameter int COL_W = 10,
   parameter int INT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_frame,
   input  logic             mode_ft,
   input  logic [INT_W-1:0] int_len,
   input  logic [ROW_W-1:0] num_rows,
   input  logic [COL_W-1:0] num_cols,
   input  logic             roi_en,
   input  logic [ROW_W-1:0] roi_row_lo,
   input  logic [ROW_W-1:0] roi_row_hi,
   input  logic [COL_W-1:0] roi_col_lo,
   input  logic [COL_W-1:0] roi_col_hi,
   input  logic             rd_active,
   input  logic             rd_ft,
   input  logic             xfer_done,
   output logic             xfer_req,
   output logic             shutter_open,
   output logic             exp_active,
   output logic             rd_start,
   output logic             c_ft,
   output logic [ROW_W-1:0] c_rows,
   output logic [COL_W-1:0] c_cols,
   output logic             c_roi_en,
   output logic [ROW_W-1:0] c_rlo,
   output logic [ROW_W-1:0] c_rhi,
   output logic [COL_W-1:0] c_clo,
   output logic [COL_W-1:0] c_chi
);

   localparam logic [INT_W-1:0] ONE_I = INT_W'(1);
   localparam logic [ROW_W-1:0] ONE_R = ROW_W'(1);

   ex_state_e        st;
   logic [INT_W-1:0] cnt;
   logic [ROW_W-1:0] dump_row;
   logic             accept, int_last, dump_last;

   // overlap only buffered-after-buffered; direct mode needs an idle reader
   assign accept    = start_frame && (st == EX_IDLE) &&
                      (!rd_active || (mode_ft && rd_ft));
   assign int_last  = (st == EX_INTEG) && (cnt == ONE_I);
   assign dump_last = (st == EX_DUMP) && xfer_done && (dump_row == c_rows - ONE_R);

   assign xfer_req     = (st == EX_DUMP);
   assign shutter_open = (st == EX_INTEG) || (st == EX_HOLD);
   assign exp_active   = (st != EX_IDLE);
   assign rd_start     = (int_last && !c_ft) || dump_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= EX_IDLE;
         cnt      <= '0;
         dump_row <= '0;
         c_ft     <= 1'b0;
         c_rows   <= '0;
         c_cols   <= '0;
         c_roi_en <= 1'b0;
         c_rlo    <= '0;
         c_rhi    <= '0;
         c_clo    <= '0;
         c_chi    <= '0;
      end else begin
         unique case (st)
            EX_IDLE: if (accept) begin
               st       <= EX_INTEG;
               cnt      <= (int_len == '0) ? ONE_I : int_len;
               c_ft     <= mode_ft;
               c_rows   <= num_rows;
               c_cols   <= num_cols;
               c_roi_en <= roi_en;
               c_rlo    <= roi_row_lo;
               c_rhi    <= roi_row_hi;
               c_clo    <= roi_col_lo;
               c_chi    <= roi_col_hi;
            end
            EX_INTEG: begin
               if (cnt == ONE_I) begin
                  dump_row <= '0;
                  if (!c_ft)          st <= EX_IDLE;
                  else if (rd_active) st <= EX_HOLD;
                  else                st <= EX_DUMP;
               end else begin
                  cnt <= cnt - ONE_I;
               end
            end
            EX_HOLD: if (!rd_active) st <= EX_DUMP;
            EX_DUMP: if (xfer_done) begin
               if (dump_last) st <= EX_IDLE;
               else           dump_row <= dump_row + ONE_R;
            end
            default: st <= EX_IDLE;
         endcase
      end
   end

   AST_XFER_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> !rd_active); // R9
   AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_done) |=> xfer_req); // R3
   AST_DIRECT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_active && !rd_ft) |-> !shutter_open); // R8
   AST_OPEN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start_frame && !exp_active && !rd_active) |=> shutter_open); // R2

endmodule

// File: rtl/ccd_raster_rd.sv
module ccd_raster_rd
   import ccd_seq_pkg::*;
#(
   parameter int ROW_W    = 10,
   parameter int COL_W    = 10,
   parameter int ADC_BITS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_start,
   input  logic             in_ft,
   input  logic [ROW_W-1:0] in_rows,
   input  logic [COL_W-1:0] in_cols,
   input  logic             in_roi_en,
   input  logic [ROW_W-1:0] in_rlo,
   input  logic [ROW_W-1:0] in_rhi,
   input  logic [COL_W-1:0] in_clo,
   input  logic [COL_W-1:0] in_chi,
   input  logic             par_shift_done,
   input  logic             ser_shift_done,
   output logic             par_shift_req,
   output logic             ser_shift_req,
   output logic             adc_convert,
   output logic             pixel_valid,
   output logic [ROW_W-1:0] row_idx,
   output logic [COL_W-1:0] col_idx,
   output logic             frame_done,
   output logic             rd_active,
   output logic             rd_ft
);

   localparam int CONV_W = (ADC_BITS > 1) ? $clog2(ADC_BITS) : 1;
   localparam logic [ROW_W-1:0] ONE_R = ROW_W'(1);
   localparam logic [COL_W-1:0] ONE_C = COL_W'(1);

   rd_state_e        st;
   logic [ROW_W-1:0] rows_q, rlo_q, rhi_q, row_q;
   logic [COL_W-1:0] cols_q, clo_q, chi_q, col_q;
   logic             roi_q, ft_q;
   logic             in_win, conv_first, conv_last, step_now, col_end, row_end;

   ccd_roi_window #(.ROW_W(ROW_W), .COL_W(COL_W)) u_win (
      .rows    (rows_q),
      .cols    (cols_q),
      .roi_en  (roi_q),
      .row_lo  (rlo_q),
      .row_hi  (rhi_q),
      .col_lo  (clo_q),
      .col_hi  (chi_q),
      .cur_row (row_q),
      .cur_col (col_q),
      .in_win  (in_win)
   );

   // conversion timer: one cycle per result bit
   generate
      if (ADC_BITS == 1) begin : g_conv_single
         assign conv_first = 1'b1;
         assign conv_last  = 1'b1;
      end else begin : g_conv_multi
         logic [CONV_W-1:0] cv;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         cv <= '0;
            else if (st != RD_CONV || conv_last) cv <= '0;
            else                                cv <= cv + CONV_W'(1);
         end
         assign conv_first = (cv == '0);
         assign conv_last  = (cv == CONV_W'(ADC_BITS - 1));
      end
   endgenerate

   assign col_end  = (col_q == cols_q - ONE_C);
   assign row_end  = (row_q == rows_q - ONE_R);
   assign step_now = ((st == RD_PIXSH) && ser_shift_done && !in_win) ||
                     ((st == RD_CONV) && conv_last);

   assign par_shift_req = (st == RD_ROWSH);
   assign ser_shift_req = (st == RD_PIXSH);
   assign adc_convert   = (st == RD_CONV) && conv_first;
   assign pixel_valid   = (st == RD_CONV) && conv_last;
   assign frame_done    = (st == RD_END);
   assign rd_active     = (st != RD_IDLE);
   assign rd_ft         = ft_q;
   assign row_idx       = row_q;
   assign col_idx       = col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RD_IDLE;
         row_q  <= '0;
         col_q  <= '0;
         rows_q <= '0;
         cols_q <= '0;
         rlo_q  <= '0;
         rhi_q  <= '0;
         clo_q  <= '0;
         chi_q  <= '0;
         roi_q  <= 1'b0;
         ft_q   <= 1'b0;
      end else if (step_now) begin
         if (!col_end) begin
            col_q <= col_q + ONE_C;
            st    <= RD_PIXSH;
         end else if (row_end) begin
            st <= RD_END;
         end else begin
            row_q <= row_q + ONE_R;
            st    <= RD_ROWSH;
         end
      end else begin
         unique case (st)
            RD_IDLE: if (rd_start) begin
               st     <= RD_ROWSH;
               row_q  <= '0;
               col_q  <= '0;
               rows_q <= in_rows;
               cols_q <= in_cols;
               rlo_q  <= in_rlo;
               rhi_q  <= in_rhi;
               clo_q  <= in_clo;
               chi_q  <= in_chi;
               roi_q  <= in_roi_en;
               ft_q   <= in_ft;
            end
            RD_ROWSH: if (par_shift_done) begin
               col_q <= '0;
               st    <= RD_PIXSH;
            end
            RD_PIXSH: if (ser_shift_done) st <= RD_CONV;
            RD_CONV:  ;
            RD_END:   st <= RD_IDLE;
            default:  st <= RD_IDLE;
         endcase
      end
   end

   AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (par_shift_req && !par_shift_done) |=> par_shift_req); // R3
   AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_shift_req && !ser_shift_done) |=> ser_shift_req); // R3
   AST_ROW_THEN_PIX: assert property (@(posedge clk) disable iff (!rst_n)
      (par_shift_req && par_shift_done) |=> ser_shift_req); // R3
   AST_ADC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_convert |=> !adc_convert); // R7
   AST_PIX_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      pixel_valid |-> in_win); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done); // R11
   AST_NO_REQ_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({par_shift_req, ser_shift_req, adc_convert})); // R3

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq #(
   parameter int ROW_W    = 10,
   parameter int COL_W    = 10,
   parameter int INT_W    = 20,
   parameter int ADC_BITS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_frame,
   input  logic             mode_ft,
   input  logic [INT_W-1:0] int_len,
   input  logic [ROW_W-1:0] num_rows,
   input  logic [COL_W-1:0] num_cols,
   input  logic             roi_en,
   input  logic [ROW_W-1:0] roi_row_lo,
   input  logic [ROW_W-1:0] roi_row_hi,
   input  logic [COL_W-1:0] roi_col_lo,
   input  logic [COL_W-1:0] roi_col_hi,
   input  logic             xfer_done,
   input  logic             par_shift_done,
   input  logic             ser_shift_done,
   output logic             xfer_req,
   output logic             par_shift_req,
   output logic             ser_shift_req,
   output logic             adc_convert,
   output logic             pixel_valid,
   output logic [ROW_W-1:0] row_idx,
   output logic [COL_W-1:0] col_idx,
   output logic             frame_done,
   output logic             shutter_open,
   output logic             busy
);

   generate
      if (ROW_W < 1 || ROW_W > 16) begin : g_bad_row
         $error("ROW_W must be within 1..16");
      end
      if (COL_W < 1 || COL_W > 16) begin : g_bad_col
         $error("COL_W must be within 1..16");
      end
      if (INT_W < 2 || INT_W > 32) begin : g_bad_int
         $error("INT_W must be within 2..32");
      end
      if (ADC_BITS < 1 || ADC_BITS > 24) begin : g_bad_adc
         $error("ADC_BITS must be within 1..24");
      end
   endgenerate

   logic             exp_active, rd_active, rd_ft, rd_start;
   logic             c_ft, c_roi_en;
   logic [ROW_W-1:0] c_rows, c_rlo, c_rhi;
   logic [COL_W-1:0] c_cols, c_clo, c_chi;

   ccd_expose_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .INT_W(INT_W)) u_exp (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_frame  (start_frame),
      .mode_ft      (mode_ft),
      .int_len      (int_len),
      .num_rows     (num_rows),
      .num_cols     (num_cols),
      .roi_en       (roi_en),
      .roi_row_lo   (roi_row_lo),
      .roi_row_hi   (roi_row_hi),
      .roi_col_lo   (roi_col_lo),
      .roi_col_hi   (roi_col_hi),
      .rd_active    (rd_active),
      .rd_ft        (rd_ft),
      .xfer_done    (xfer_done),
      .xfer_req     (xfer_req),
      .shutter_open (shutter_open),
      .exp_active   (exp_active),
      .rd_start     (rd_start),
      .c_ft         (c_ft),
      .c_rows       (c_rows),
      .c_cols       (c_cols),
      .c_roi_en     (c_roi_en),
      .c_rlo        (c_rlo),
      .c_rhi        (c_rhi),
      .c_clo        (c_clo),
      .c_chi        (c_chi)
   );

   ccd_raster_rd #(.ROW_W(ROW_W), .COL_W(COL_W), .ADC_BITS(ADC_BITS)) u_rd (
      .clk            (clk),
      .rst_n          (rst_n),
      .rd_start       (rd_start),
      .in_ft          (c_ft),
      .in_rows        (c_rows),
      .in_cols        (c_cols),
      .in_roi_en      (c_roi_en),
      .in_rlo         (c_rlo),
      .in_rhi         (c_rhi),
      .in_clo         (c_clo),
      .in_chi         (c_chi),
      .par_shift_done (par_shift_done),
      .ser_shift_done (ser_shift_done),
      .par_shift_req  (par_shift_req),
      .ser_shift_req  (ser_shift_req),
      .adc_convert    (adc_convert),
      .pixel_valid    (pixel_valid),
      .row_idx        (row_idx),
      .col_idx        (col_idx),
      .frame_done     (frame_done),
      .rd_active      (rd_active),
      .rd_ft          (rd_ft)
   );

   assign busy = exp_active || rd_active;

   AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
      (shutter_open || xfer_req || par_shift_req || ser_shift_req) |-> busy); // R12
   AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !shutter_open && !xfer_req && !start_frame) |=> !busy); // R12

endmodule

// File: tb/tb_ccd_readout_seq.sv
module tb_ccd_readout_seq;

   localparam int TCLK  = 10;
   localparam int RW    = 10;
   localparam int CW    = 10;
   localparam int IW    = 20;
   localparam int ADC_B = 12;
   localparam int LIMIT = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_frame = 1'b0;
   logic          mode_ft = 1'b0;
   logic [IW-1:0] int_len = '0;
   logic [RW-1:0] num_rows = RW'(1);
   logic [CW-1:0] num_cols = CW'(1);
   logic          roi_en = 1'b0;
   logic [RW-1:0] roi_row_lo = '0, roi_row_hi = '0;
   logic [CW-1:0] roi_col_lo = '0, roi_col_hi = '0;
   logic          xfer_done = 1'b0, par_shift_done = 1'b0, ser_shift_done = 1'b0;
   logic          xfer_req, par_shift_req, ser_shift_req, adc_convert, pixel_valid;
   logic [RW-1:0] row_idx;
   logic [CW-1:0] col_idx;
   logic          frame_done, shutter_open, busy;

   ccd_readout_seq #(.ROW_W(RW), .COL_W(CW), .INT_W(IW), .ADC_BITS(ADC_B)) dut (
      .clk(clk), .rst_n(rst_n), .start_frame(start_frame), .mode_ft(mode_ft),
      .int_len(int_len), .num_rows(num_rows), .num_cols(num_cols), .roi_en(roi_en),
      .roi_row_lo(roi_row_lo), .roi_row_hi(roi_row_hi),
      .roi_col_lo(roi_col_lo), .roi_col_hi(roi_col_hi),
      .xfer_done(xfer_done), .par_shift_done(par_shift_done), .ser_shift_done(ser_shift_done),
      .xfer_req(xfer_req), .par_shift_req(par_shift_req), .ser_shift_req(ser_shift_req),
      .adc_convert(adc_convert), .pixel_valid(pixel_valid), .row_idx(row_idx),
      .col_idx(col_idx), .frame_done(frame_done), .shutter_open(shutter_open), .busy(busy)
   );

   always #(TCLK/2) clk = ~clk;

   int n_chk = 0, n_bad = 0, cycles = 0;
   int lat_x = 0, lat_p = 0, lat_s = 0;
   int wx = 0, wp = 0, ws = 0;
   int frames = 0, pix_seen = 0, ser_hs = 0, par_hs = 0;
   int open_run = 0, last_open = 0, overlap = 0;
   int exp_pix[$];

   // behavioural reference: phases 0 idle,1 exposing,2 holding,3 storing / 0 idle,1 row,2 pixel,3 convert,4 end
   int m_e = 0, m_cnt = 0, m_dump = 0;
   int e_ft = 0, e_rows = 1, e_cols = 1, e_roi = 0, e_rl = 0, e_rh = 0, e_cl = 0, e_ch = 0;
   int m_r = 0, m_row = 0, m_col = 0, m_cv = 0;
   int r_ft = 0, r_rows = 1, r_cols = 1, r_roi = 0, r_rl = 0, r_rh = 0, r_cl = 0, r_ch = 0;

   function automatic bit wanted(int r, int c, int rows, int cols, int en,
                                 int rl, int rh, int cl, int ch);
      bit good;
      good = (en != 0) && (rl <= rh) && (rh < rows) && (cl <= ch) && (ch < cols);
      if (!good) return 1'b1;
      return (r >= rl) && (r <= rh) && (c >= cl) && (c <= ch);
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cycles);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_e = 0; m_r = 0; m_cnt = 0; m_dump = 0; m_row = 0; m_col = 0; m_cv = 0; r_ft = 0;
      end else begin
         bit go, acc, r_busy, adv;
         go = 1'b0;
         r_busy = (m_r != 0);
         acc = start_frame && (m_e == 0) && (!r_busy || (mode_ft && r_ft != 0));
         case (m_e)
            0: if (acc) begin
               m_e = 1; m_cnt = (int_len == 0) ? 1 : int'(int_len);
               e_ft = mode_ft; e_rows = num_rows; e_cols = num_cols; e_roi = roi_en;
               e_rl = roi_row_lo; e_rh = roi_row_hi; e_cl = roi_col_lo; e_ch = roi_col_hi;
            end
            1: if (m_cnt == 1) begin
               m_dump = 0;
               if (e_ft == 0) begin m_e = 0; go = 1'b1; end
               else m_e = r_busy ? 2 : 3;
            end else m_cnt--;
            2: if (!r_busy) m_e = 3;
            3: if (xfer_done) begin
               if (m_dump == e_rows - 1) begin m_e = 0; go = 1'b1; end
               else m_dump++;
            end
            default: ;
         endcase
         adv = 1'b0;
         case (m_r)
            0: if (go) begin
               m_r = 1; m_row = 0; m_col = 0;
               r_ft = e_ft; r_rows = e_rows; r_cols = e_cols; r_roi = e_roi;
               r_rl = e_rl; r_rh = e_rh; r_cl = e_cl; r_ch = e_ch;
               for (int r = 0; r < r_rows; r++)
                  for (int c = 0; c < r_cols; c++)
                     if (wanted(r, c, r_rows, r_cols, r_roi, r_rl, r_rh, r_cl, r_ch))
                        exp_pix.push_back(r * 1024 + c);
            end
            1: if (par_shift_done) begin m_r = 2; m_col = 0; end
            2: if (ser_shift_done) begin
               if (wanted(m_row, m_col, r_rows, r_cols, r_roi, r_rl, r_rh, r_cl, r_ch)) begin
                  m_r = 3; m_cv = 0;
               end else adv = 1'b1;
            end
            3: if (m_cv == ADC_B - 1) adv = 1'b1; else m_cv++;
            4: m_r = 0;
            default: ;
         endcase
         if (adv) begin
            if (m_col < r_cols - 1) begin m_col++; m_r = 2; end
            else if (m_row < r_rows - 1) begin m_row++; m_r = 1; end
            else m_r = 4;
         end
      end
   end

   // compare every cycle, then act as the phase clock generator
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         check(shutter_open == (m_e == 1 || m_e == 2), "R2/R8 shutter_open", shutter_open, (m_e == 1 || m_e == 2));
         check(xfer_req == (m_e == 3), "R9 xfer_req", xfer_req, (m_e == 3));
         check(par_shift_req == (m_r == 1), "R3 par_shift_req", par_shift_req, (m_r == 1));
         check(ser_shift_req == (m_r == 2), "R3 ser_shift_req", ser_shift_req, (m_r == 2));
         check(adc_convert == (m_r == 3 && m_cv == 0), "R7 adc_convert", adc_convert, (m_r == 3 && m_cv == 0));
         check(pixel_valid == (m_r == 3 && m_cv == ADC_B - 1), "R7 pixel_valid", pixel_valid, (m_r == 3 && m_cv == ADC_B - 1));
         check(frame_done == (m_r == 4), "R11 frame_done", frame_done, (m_r == 4));
         check(busy == (m_e != 0 || m_r != 0), "R12 busy", busy, (m_e != 0 || m_r != 0));
         if (pixel_valid) begin
            int want;
            want = (exp_pix.size() > 0) ? exp_pix.pop_front() : -1;
            check(want == int'(row_idx) * 1024 + int'(col_idx), "R4/R5 raster position",
                  int'(row_idx) * 1024 + int'(col_idx), want);
            pix_seen++;
         end
         if (shutter_open && (par_shift_req || ser_shift_req || adc_convert)) overlap++;
         if (shutter_open) open_run++;
         else if (open_run != 0) begin last_open = open_run; open_run = 0; end
         if (frame_done) begin
            check(exp_pix.size() == 0, "R5/R6 pixels left over", exp_pix.size(), 0);
            exp_pix.delete();
            frames++;
         end
      end
      if (xfer_done) begin xfer_done = 1'b0; wx = 0; end
      else if (xfer_req) begin if (wx >= lat_x) xfer_done = 1'b1; else wx++; end
      if (par_shift_done) begin par_shift_done = 1'b0; wp = 0; end
      else if (par_shift_req) begin if (wp >= lat_p) begin par_shift_done = 1'b1; par_hs++; end else wp++; end
      if (ser_shift_done) begin ser_shift_done = 1'b0; ws = 0; end
      else if (ser_shift_req) begin if (ws >= lat_s) begin ser_shift_done = 1'b1; ser_hs++; end else ws++; end
      if (cycles > LIMIT) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   task automatic setup(int ft, int il, int rows, int cols, int en, int rl, int rh, int cl, int ch);
      mode_ft = ft[0]; int_len = IW'(il); num_rows = RW'(rows); num_cols = CW'(cols);
      roi_en = en[0]; roi_row_lo = RW'(rl); roi_row_hi = RW'(rh);
      roi_col_lo = CW'(cl); roi_col_hi = CW'(ch);
   endtask

   task automatic pulse_start();
      @(negedge clk); start_frame = 1'b1;
      @(negedge clk); start_frame = 1'b0;
   endtask

   task automatic wait_frames(int target);
      while (frames < target) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      int f0, s0, p0, v0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check({xfer_req, par_shift_req, ser_shift_req, adc_convert, pixel_valid, frame_done, shutter_open, busy} == 8'h00,
            "R1 outputs in reset", {xfer_req, par_shift_req, ser_shift_req, adc_convert, pixel_valid, frame_done, shutter_open, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && shutter_open == 1'b0, "R1 idle after reset", busy, 0);

      // direct mode, whole array
      setup(0, 3, 4, 5, 0, 0, 0, 0, 0);
      s0 = ser_hs; p0 = par_hs; v0 = pix_seen;
      pulse_start();
      wait_frames(1);
      check(last_open == 3, "R2 exposure length", last_open, 3);
      check(ser_hs - s0 == 20, "R3 pixel transfers", ser_hs - s0, 20);
      check(par_hs - p0 == 4, "R3 row transfers", par_hs - p0, 4);
      check(pix_seen - v0 == 20, "R4 converted pixels", pix_seen - v0, 20);

      // valid window, slow handshakes
      lat_p = 2; lat_s = 1;
      setup(0, 0, 4, 5, 1, 1, 2, 1, 3);
      s0 = ser_hs; v0 = pix_seen;
      pulse_start();
      wait_frames(2);
      check(last_open == 1, "R2 zero length acts as one", last_open, 1);
      check(pix_seen - v0 == 6, "R5 window pixels", pix_seen - v0, 6);
      check(ser_hs - s0 == 20, "R5 all pixels still transferred", ser_hs - s0, 20);

      // invalid windows fall back to the whole array
      lat_p = 0; lat_s = 0;
      setup(0, 2, 3, 4, 1, 0, 2, 1, 4);
      v0 = pix_seen;
      pulse_start();
      wait_frames(3);
      check(pix_seen - v0 == 12, "R6 column beyond array", pix_seen - v0, 12);
      setup(0, 2, 3, 4, 1, 2, 1, 0, 3);
      v0 = pix_seen;
      pulse_start();
      wait_frames(4);
      check(pix_seen - v0 == 12, "R6 reversed rows", pix_seen - v0, 12);

      // start while busy is ignored (R10)
      setup(0, 4, 2, 3, 0, 0, 0, 0, 0);
      v0 = pix_seen; f0 = frames;
      pulse_start();
      setup(0, 9, 5, 5, 0, 0, 0, 0, 0);
      pulse_start();
      while (!par_shift_req) @(negedge clk);
      pulse_start();
      @(negedge clk);
      check(shutter_open == 1'b0, "R10 start during readout ignored", shutter_open, 0);
      check(busy == 1'b1, "R12 busy during readout", busy, 1);
      wait_frames(f0 + 1);
      repeat (30) @(negedge clk);
      check(frames == f0 + 1, "R10 no extra frame", frames, f0 + 1);
      check(pix_seen - v0 == 6, "R10 first config kept", pix_seen - v0, 6);

      // buffered mode with overlapping exposure
      lat_x = 1; lat_p = 1; lat_s = 0;
      setup(1, 2, 3, 4, 0, 0, 0, 0, 0);
      f0 = frames; overlap = 0; v0 = pix_seen;
      pulse_start();
      while (!par_shift_req) @(negedge clk);
      setup(1, 5, 2, 3, 1, 0, 1, 1, 2);
      pulse_start();
      wait_frames(f0 + 2);
      check(overlap > 0, "R9 exposure overlaps readout", overlap, 1);
      check(pix_seen - v0 == 16, "R9 both buffered frames read", pix_seen - v0, 16);

      // direct start while buffered readout runs is ignored
      setup(1, 1, 3, 3, 0, 0, 0, 0, 0);
      f0 = frames;
      pulse_start();
      while (!par_shift_req) @(negedge clk);
      setup(0, 2, 3, 3, 0, 0, 0, 0, 0);
      pulse_start();
      @(negedge clk);
      check(shutter_open == 1'b0, "R10 direct start vs buffered readout", shutter_open, 0);
      wait_frames(f0 + 1);
      repeat (30) @(negedge clk);
      check(frames == f0 + 1, "R8 no direct frame started", frames, f0 + 1);
      check(busy == 1'b0, "R12 idle at end", busy, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule